// File: doc/BRIEF.md
# Operand Effective Address Unit

This block resolves one instruction operand. It takes a 4-bit mode code, a short address field, a register select, and the address of the current instruction. It then produces either the operand value itself or the effective address at which the operand lives. A flag tells which of the two the result is. The register file is read through a combinational read port: the block drives the register number and the value returns in the same cycle. Modes that need a word from memory fetch it over a valid/ready read port.

A request is accepted on `start` while the block is idle. Modes that need no memory finish one clock later. Indirect modes wait in a fetch state until the read handshake completes, then report. The autoincrement mode also asks for a register write of the index plus one, in the same cycle that `done` is high.

The controller has three states. IDLE waits for `start`. FETCH drives the memory read and waits for `mem_rd_ready`. DONE presents the result for exactly one cycle. The transitions are:
- IDLE→DONE on `start` with a mode that needs no memory read.
- IDLE→FETCH on `start` with one of the three indirect modes.
- FETCH→DONE when the read handshake completes.
- DONE→IDLE always.

Top module: `oper_ea_unit`

## Requirements
- R1: Mode 0 (immediate) returns the 6-bit address field sign-extended to 16 bits, with `is_operand`=1 and no memory read.
- R2: Mode 1 (direct) returns the address field zero-extended, with `is_operand`=0.
- R3: Mode 2 (indirect) issues exactly one memory read at the zero-extended address field; the returned word is the result.
- R4: Mode 3 (register) returns the contents of register `rsel` as an operand (`is_operand`=1).
- R5: Mode 4 (register indirect) returns the contents of register `rsel` as an address.
- R6: Modes 5 (base displacement) and 6 (indexed) return the zero-extended field plus register `rsel`, modulo 2^16.
- R7: Mode 7 (PC-relative) returns `pc` plus the sign-extended field, modulo 2^16.
- R8: Mode 8 (pre-indexed indirect) reads memory at the field plus register `rsel`; the word read is the result.
- R9: Mode 9 (post-indexed indirect) reads memory at the zero-extended field, then returns that word plus register `rsel` as sampled at `start`.
- R10: Mode 10 (autoincrement indexed) returns the field plus register `rsel`. While `done` is high it raises `wb_en` with `wb_addr`=`rsel` and `wb_data` = old register value + 1. No other mode raises `wb_en`.
- R11: Mode 11 (stack) reads register 15 regardless of `rsel` and returns its contents as the address.
- R12: Mode codes 12 to 15 finish one cycle after `start` with `illegal`=1, result 0, no memory read and no write-back.
- R13: Non-indirect modes raise `done` on the clock after `start` is accepted. Indirect modes raise `done` on the clock after the read handshake. `done` is a one-cycle pulse. `mem_rd_valid` and `mem_rd_addr` hold steady until `mem_rd_ready`. `start` is ignored outside IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request; accepted only in IDLE |
| mode | input | 4 | Addressing mode code |
| afield | input | 6 | Address / immediate field |
| rsel | input | 4 | Register select |
| pc | input | 16 | Address of the current instruction |
| rf_addr | output | 4 | Register file read index (combinational) |
| rf_data | input | 16 | Register file read data |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_ready | input | 1 | Memory read accepted; data valid this cycle |
| mem_rd_data | input | 16 | Memory read data |
| result | output | 16 | Operand or effective address, valid with `done` |
| is_operand | output | 1 | 1 when `result` is an operand value |
| illegal | output | 1 | Unsupported mode code |
| wb_en | output | 1 | Autoincrement register write request |
| wb_addr | output | 4 | Write-back register index |
| wb_data | output | 16 | Write-back value |
| done | output | 1 | Result valid, one cycle |

## Verification
The bench targets sign handling: an immediate and a PC-relative field with the top bit set must extend negatively, and a design that zero-extends would land 64 too high. A displacement that wraps past 0xFFFF catches an adder that is wider than the word. The post-indexed case uses a nonzero index and a stalled memory so that the index is added after the read, not to the read address. A `start` is held high during that stall, and a design that re-accepted it would corrupt the result. Two autoincrements back to back show whether the write-back carries old-value-plus-one and whether the write-back pulse is tied to `done`.

// File: rtl/oea_pkg.sv
package oea_pkg;

    typedef enum logic [3:0] {
        AM_IMM     = 4'd0,
        AM_DIR     = 4'd1,
        AM_IND     = 4'd2,
        AM_REG     = 4'd3,
        AM_RIND    = 4'd4,
        AM_BASE    = 4'd5,
        AM_IDX     = 4'd6,
        AM_PCREL   = 4'd7,
        AM_PREIND  = 4'd8,
        AM_POSTIND = 4'd9,
        AM_AUTOINC = 4'd10,
        AM_STACK   = 4'd11
    } amode_e;

    typedef struct packed {
        logic legal;
        logic operand;
        logic mem_rd;
        logic post_idx;
        logic autoinc;
        logic use_sp;
    } ainfo_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DONE
    } ast_e;

endpackage

// File: rtl/oea_decode.sv
module oea_decode
    import oea_pkg::*;
(
    input  logic [3:0] mode_i,
    output ainfo_t     info_o
);
    always_comb begin
        info_o       = '0;
        info_o.legal = 1'b1;
        case (mode_i)
            AM_IMM, AM_REG:          info_o.operand  = 1'b1;
            AM_DIR, AM_RIND,
            AM_BASE, AM_IDX,
            AM_PCREL:                info_o.operand  = 1'b0;
            AM_IND, AM_PREIND:       info_o.mem_rd   = 1'b1;
            AM_POSTIND: begin
                info_o.mem_rd   = 1'b1;
                info_o.post_idx = 1'b1;
            end
            AM_AUTOINC:              info_o.autoinc  = 1'b1;
            AM_STACK:                info_o.use_sp   = 1'b1;
            default:                 info_o.legal    = 1'b0;
        endcase
    end
endmodule

// File: rtl/oea_calc.sv
module oea_calc
    import oea_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int AFIELD_W = 6
) (
    input  logic [3:0]          mode_i,
    input  logic [AFIELD_W-1:0] afield_i,
    input  logic [WORD_W-1:0]   regv_i,
    input  logic [WORD_W-1:0]   pc_i,
    output logic [WORD_W-1:0]   value_o
);
    localparam int EXT_W = WORD_W - AFIELD_W;

    logic [WORD_W-1:0] a_zext;
    logic [WORD_W-1:0] a_sext;

    assign a_zext = {{EXT_W{1'b0}}, afield_i};
    assign a_sext = {{EXT_W{afield_i[AFIELD_W-1]}}, afield_i};

    always_comb begin
        case (mode_i)
            AM_IMM:                          value_o = a_sext;
            AM_DIR, AM_IND, AM_POSTIND:      value_o = a_zext;
            AM_REG, AM_RIND, AM_STACK:       value_o = regv_i;
            AM_BASE, AM_IDX,
            AM_PREIND, AM_AUTOINC:           value_o = a_zext + regv_i;
            AM_PCREL:                        value_o = pc_i + a_sext;
            default:                         value_o = '0;
        endcase
    end
endmodule

// File: rtl/oper_ea_unit.sv
module oper_ea_unit
    import oea_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int AFIELD_W = 6,
    parameter int RSEL_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [3:0]          mode,
    input  logic [AFIELD_W-1:0] afield,
    input  logic [RSEL_W-1:0]   rsel,
    input  logic [WORD_W-1:0]   pc,
    output logic [RSEL_W-1:0]   rf_addr,
    input  logic [WORD_W-1:0]   rf_data,
    output logic                mem_rd_valid,
    output logic [WORD_W-1:0]   mem_rd_addr,
    input  logic                mem_rd_ready,
    input  logic [WORD_W-1:0]   mem_rd_data,
    output logic [WORD_W-1:0]   result,
    output logic                is_operand,
    output logic                illegal,
    output logic                wb_en,
    output logic [RSEL_W-1:0]   wb_addr,
    output logic [WORD_W-1:0]   wb_data,
    output logic                done
);
    localparam int                NREG   = 1 << RSEL_W;
    localparam logic [RSEL_W-1:0] SP_SEL = RSEL_W'(NREG - 1);

    ast_e              state_q, state_d;
    ainfo_t            info;
    logic [WORD_W-1:0] early_w;
    logic              accept_w;
    logic              idle_w;

    logic [WORD_W-1:0] res_q, idx_q, wbd_q;
    logic [RSEL_W-1:0] wba_q;
    logic              op_q, ill_q, wbp_q, post_q;

    oea_decode u_decode (
        .mode_i (mode),
        .info_o (info)
    );

    oea_calc #(
        .WORD_W   (WORD_W),
        .AFIELD_W (AFIELD_W)
    ) u_calc (
        .mode_i   (mode),
        .afield_i (afield),
        .regv_i   (rf_data),
        .pc_i     (pc),
        .value_o  (early_w)
    );

    assign idle_w   = (state_q == ST_IDLE);
    assign accept_w = idle_w && start;
    assign rf_addr  = info.use_sp ? SP_SEL : rsel;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = info.mem_rd ? ST_FETCH : ST_DONE;
            ST_FETCH: if (mem_rd_ready) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            idx_q  <= '0;
            wbd_q  <= '0;
            wba_q  <= '0;
            op_q   <= 1'b0;
            ill_q  <= 1'b0;
            wbp_q  <= 1'b0;
            post_q <= 1'b0;
        end else if (accept_w) begin
            res_q  <= early_w;
            idx_q  <= rf_data;
            wbd_q  <= rf_data + WORD_W'(1);
            wba_q  <= rsel;
            op_q   <= info.operand;
            ill_q  <= ~info.legal;
            wbp_q  <= info.autoinc;
            post_q <= info.post_idx;
        end else if (state_q == ST_FETCH && mem_rd_ready) begin
            res_q  <= post_q ? (mem_rd_data + idx_q) : mem_rd_data;
        end
    end

    // outputs
    always_comb begin
        done         = (state_q == ST_DONE);
        mem_rd_valid = (state_q == ST_FETCH);
        mem_rd_addr  = res_q;
        result       = res_q;
        is_operand   = op_q;
        illegal      = ill_q;
        wb_en        = done && wbp_q;
        wb_addr      = wba_q;
        wb_data      = wbd_q;
    end
endmodule

// File: rtl/oea_checker.sv
module oea_checker #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              idle,
    input logic [3:0]        mode,
    input logic              done,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic [WORD_W-1:0] mem_rd_addr,
    input logic              wb_en,
    input logic              illegal,
    input logic              is_operand
);
    a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r13_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    a_r13_handshake_done: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && mem_rd_ready) |=> (done && !mem_rd_valid));

    a_r13_fast_done: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && mode != 4'd2 && mode != 4'd8 && mode != 4'd9) |=> (done && !mem_rd_valid));

    a_r12_illegal_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && mode >= 4'd12) |=> (done && illegal && !wb_en));

    a_r10_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (done && !illegal));

    a_r1_imm_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && mode == 4'd0) |=> (is_operand && !mem_rd_valid));
endmodule

bind oper_ea_unit oea_checker #(.WORD_W(WORD_W)) u_oea_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .idle         (idle_w),
    .mode         (mode),
    .done         (done),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr),
    .wb_en        (wb_en),
    .illegal      (illegal),
    .is_operand   (is_operand)
);

// File: tb/oper_ea_unit_bench.sv
module oper_ea_unit_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [5:0]  afield = '0;
    logic [3:0]  rsel = '0;
    logic [15:0] pc = '0;
    logic [3:0]  rf_addr;
    logic [15:0] rf_data;
    logic        mem_rd_valid;
    logic [15:0] mem_rd_addr;
    logic        mem_rd_ready = 1'b0;
    logic [15:0] mem_rd_data = '0;
    logic [15:0] result;
    logic        is_operand, illegal, wb_en, done;
    logic [3:0]  wb_addr;
    logic [15:0] wb_data;

    logic [15:0] regs [16];
    int n_tests = 0;
    int n_fail  = 0;
    bit mon_on  = 1'b0;
    bit exp_done = 1'b0, exp_rd = 1'b0, exp_wb = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    oper_ea_unit u_oper_ea_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .afield(afield),
        .rsel(rsel), .pc(pc), .rf_addr(rf_addr), .rf_data(rf_data),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
        .result(result), .is_operand(is_operand), .illegal(illegal),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data), .done(done)
    );

    assign rf_data = regs[rf_addr];

    always @(posedge clk) if (wb_en) regs[wb_addr] <= wb_data;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int m);
        case (m)
            0: return "R1";   1: return "R2";   2: return "R3";
            3: return "R4";   4: return "R5";   5, 6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; 11: return "R11";
            default: return "R12";
        endcase
    endfunction

    // per-clock comparison of the handshake-level outputs (R13)
    always @(negedge clk) begin
        #1;
        if (mon_on) begin
            chk(done == exp_done, "R13 done timing", int'(done), int'(exp_done));
            chk(mem_rd_valid == exp_rd, "R13 read valid timing", int'(mem_rd_valid), int'(exp_rd));
            chk(wb_en == exp_wb, "R10 wb_en timing", int'(wb_en), int'(exp_wb));
        end
    end

    task automatic issue(input int m, input int a, input int r, input int pcv,
                         input int wt, input int word, input bit hold_start);
        int sx, rv, res, rdaddr, wbd;
        bit mem, opnd, ill, wbx;
        string tg;
        tg   = tag_of(m);
        sx   = (a >= 32) ? a - 64 : a;
        rv   = (m == 11) ? int'(regs[15]) : int'(regs[r]);
        mem  = 0; opnd = 0; ill = 0; wbx = 0; rdaddr = 0; res = 0;
        wbd  = (rv + 1) & 16'hFFFF;
        case (m)
            0:    begin res = sx & 16'hFFFF; opnd = 1; end
            1:    res = a;
            2:    begin mem = 1; rdaddr = a; res = word; end
            3:    begin res = rv; opnd = 1; end
            4:    res = rv;
            5, 6: res = (a + rv) & 16'hFFFF;
            7:    res = (pcv + sx) & 16'hFFFF;
            8:    begin mem = 1; rdaddr = (a + rv) & 16'hFFFF; res = word; end
            9:    begin mem = 1; rdaddr = a; res = (word + rv) & 16'hFFFF; end
            10:   begin res = (a + rv) & 16'hFFFF; wbx = 1; end
            11:   res = rv;
            default: begin ill = 1; res = 0; end
        endcase
        @(negedge clk);
        mode = 4'(m); afield = 6'(a); rsel = 4'(r); pc = 16'(pcv); start = 1'b1;
        @(negedge clk);
        if (mem) begin
            if (hold_start) begin mode = 4'd0; afield = 6'd1; end
            else start = 1'b0;
            exp_rd = 1'b1;
            chk(mem_rd_addr == 16'(rdaddr), {tg, " read address"}, int'(mem_rd_addr), rdaddr);
            repeat (wt) begin
                @(negedge clk);
                chk(mem_rd_addr == 16'(rdaddr), "R13 read address held", int'(mem_rd_addr), rdaddr);
            end
            mem_rd_ready = 1'b1;
            mem_rd_data  = 16'(word);
            start = 1'b0;
            @(negedge clk);
            mem_rd_ready = 1'b0;
            mem_rd_data  = 16'hDEAD;
            exp_rd = 1'b0;
        end
        start    = 1'b0;
        exp_done = 1'b1;
        exp_wb   = wbx;
        chk(result == 16'(res), {tg, " result"}, int'(result), res);
        chk(is_operand == opnd, {tg, " is_operand"}, int'(is_operand), int'(opnd));
        chk(illegal == ill, {tg, " illegal flag"}, int'(illegal), int'(ill));
        if (wbx) begin
            chk(wb_addr == 4'(r), "R10 wb_addr", int'(wb_addr), r);
            chk(wb_data == 16'(wbd), "R10 wb_data", int'(wb_data), wbd);
        end
        @(negedge clk);
        exp_done = 1'b0;
        exp_wb   = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 16'(16'h1000 + i * 16'h0111);
        regs[3]  = 16'h00F0;
        regs[5]  = 16'hFFFE;
        regs[15] = 16'h7F00;
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && mem_rd_valid == 1'b0 && wb_en == 1'b0,
            "R13 reset state", int'({done, mem_rd_valid, wb_en}), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        issue(0,  6'h25, 1, 0,        0, 0,       0);  // R1 negative immediate
        issue(0,  6'h1A, 1, 0,        0, 0,       0);  // R1 positive immediate
        issue(1,  6'h3F, 0, 0,        0, 0,       0);  // R2
        issue(2,  6'h12, 0, 0,        2, 16'hBEEF, 0); // R3 with stall
        issue(3,  0,     3, 0,        0, 0,       0);  // R4
        issue(4,  0,     5, 0,        0, 0,       0);  // R5
        issue(5,  6'h05, 5, 0,        0, 0,       0);  // R6 wraps to 0x0003
        issue(6,  6'h10, 3, 0,        0, 0,       0);  // R6 indexed
        issue(7,  6'h3E, 0, 16'h0200, 0, 0,       0);  // R7 backward
        issue(7,  6'h05, 0, 16'h0200, 0, 0,       0);  // R7 forward
        issue(8,  6'h02, 3, 0,        0, 16'h1234, 0); // R8
        issue(9,  6'h07, 3, 0,        3, 16'h1000, 1); // R9, start held while busy (R13)
        issue(10, 6'h01, 3, 0,        0, 0,       0);  // R10 first
        issue(10, 6'h01, 3, 0,        0, 0,       0);  // R10 uses updated index
        issue(11, 0,     3, 0,        0, 0,       0);  // R11 ignores rsel
        issue(12, 6'h3F, 2, 0,        0, 0,       0);  // R12
        issue(15, 0,     0, 0,        0, 0,       0);  // R12
        issue(3,  0,     3, 0,        0, 0,       0);  // R4 after write-back
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R13 watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule